// File: doc/BRIEF.md
# Prescaled Countdown Timer

A 32-bit down-counter paced by a 32-bit prescaler, reached over a simple register bus. The prescaler sets how many clock cycles make up one count step. Long intervals of minutes, hours or days can therefore be timed at a system clock in the tens of megahertz. The block has no notion of privilege: any bus initiator, whether firmware or application code, can program it and read it.

Software first writes a starting value and a prescale value while the timer is idle. It then issues a start command through the control register. From there the count falls by one for every full prescaler period. It halts when it reaches one, not zero, and the running flag then drops. Software polls the count register and the status flag to see progress. A stop command freezes the count where it stands. No interrupt is raised.

Top module: `prescale_timer`

## Requirements
- R1: After reset, every readable register reads zero: the count (address 4), the status flag (address 1), the starting value (address 2) and the prescale value (address 3).
- R2: While the timer is idle, a write to address 2 sets the starting value and a write to address 3 sets the prescale value, and each reads back unchanged on the next cycle.
- R3: A write to the control register (address 0) with bit 0 set is a start command. At that clock edge the count loads the starting value, the prescaler restarts from zero, and status bit 0 becomes 1 if the starting value is greater than one.
- R4: While running, the count falls by exactly one on every (prescale + 1)-th clock edge after the start edge, and at no other edge.
- R5: The edge that takes the count from two to one also clears status bit 0; the count then holds at one.
- R6: A start command with a starting value of 0 or 1 loads that value into the count and leaves status bit 0 at 0, and the count does not change afterwards.
- R7: A control write with bit 1 set and bit 0 clear is a stop command: status bit 0 clears at that edge and the count holds its value.
- R8: While status bit 0 is 1, writes to addresses 2 and 3 are ignored and the old values still read back.
- R9: A start command while running reloads the count from the starting value and restarts the prescaler; when bits 0 and 1 are both set, the start takes priority.
- R10: Reads return zero for the control register, for unmapped addresses (5 to 15), and whenever the read strobe is not asserted; bits 31:1 of the status register read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current access |

## Verification
The bench goes after the pacing of count steps with a prescale of zero, one and three. A design that is off by one in the prescaler would step a cycle early or late. The terminal edge is probed at the two-to-one step: a design that counted to zero, or lowered the flag one cycle late, would show count 0 or a stale busy flag. Starting values of 0 and 1 catch a timer that starts running and wraps. Writes during a run, a restart mid-run and a combined start-plus-stop command catch a design that lets the configuration change under a live count, or that lets stop win.

// File: rtl/timer_pkg.sv
// Shared register addresses and control-bit positions for the prescaled timer.
// Assumes word addressing on the register bus.
package timer_pkg;
    localparam int REG_CTRL   = 0;
    localparam int REG_STATUS = 1;
    localparam int REG_START  = 2;
    localparam int REG_SCALE  = 3;
    localparam int REG_COUNT  = 4;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_HALT_BIT = 1;
endpackage

// File: rtl/timer_regs.sv
// Register file and bus decode. Holds the starting value and prescale value,
// turns control writes into one-cycle start/stop pulses, and muxes read data.
// Assumes the bus is single-cycle: a strobed write takes effect at that edge.
module timer_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              running,
    input  logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] start_val,
    output logic [DATA_W-1:0] scale_val,
    output logic              go_cmd,
    output logic              halt_cmd,
    output logic [DATA_W-1:0] bus_rdata
);
    import timer_pkg::*;

    logic wr_en;
    logic rd_en;

    assign wr_en = bus_cs && bus_we;
    assign rd_en = bus_cs && !bus_we;

    // Decode control writes into command pulses; start outranks stop.
    always_comb begin
        go_cmd   = wr_en && (bus_addr == ADDR_W'(REG_CTRL)) && bus_wdata[CTRL_GO_BIT];
        halt_cmd = wr_en && (bus_addr == ADDR_W'(REG_CTRL)) && bus_wdata[CTRL_HALT_BIT]
                   && !bus_wdata[CTRL_GO_BIT];
    end

    // Configuration registers, writable only while the timer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_val <= '0;
            scale_val <= '0;
        end else if (wr_en && !running) begin
            if (bus_addr == ADDR_W'(REG_START)) start_val <= bus_wdata;
            if (bus_addr == ADDR_W'(REG_SCALE)) scale_val <= bus_wdata;
        end
    end

    // Read mux; zero for control, unmapped words and idle bus.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                ADDR_W'(REG_STATUS): bus_rdata = DATA_W'(running);
                ADDR_W'(REG_START):  bus_rdata = start_val;
                ADDR_W'(REG_SCALE):  bus_rdata = scale_val;
                ADDR_W'(REG_COUNT):  bus_rdata = count;
                default:             bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/timer_prescaler.sv
// Clock divider: counts 0..limit while enabled and pulses tick on the cycle
// it sits at limit, then wraps to zero. Restart forces it back to zero.
// Assumes limit is held stable while enabled.
module timer_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         enable,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] phase;

    assign tick = enable && (phase == limit);

    // Phase counter: clear on restart, wrap after limit, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= '0;
        end else if (enable) begin
            phase <= tick ? '0 : phase + W'(1);
        end
    end
endmodule

// File: rtl/timer_core.sv
// Count register and running flag. Loads on start, freezes on stop, steps
// down on each prescaler tick and halts at one.
// Assumes go and halt are never both asserted (decoder gives start priority).
module timer_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         halt,
    input  logic         tick,
    input  logic [W-1:0] start_val,
    output logic [W-1:0] count,
    output logic         running
);
    localparam logic [W-1:0] LAST_STEP = W'(2);
    localparam logic [W-1:0] FLOOR     = W'(1);

    // Count and run-state update, priority start > stop > tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
        end else if (go) begin
            count   <= start_val;
            running <= (start_val > FLOOR);
        end else if (halt) begin
            running <= 1'b0;
        end else if (running && tick) begin
            count <= count - W'(1);
            if (count == LAST_STEP) running <= 1'b0;
        end
    end
endmodule

// File: rtl/prescale_timer.sv
// Top of the prescaled countdown timer: register file, prescaler and counter.
// Assumes a single-cycle register bus with combinational read data.
module prescale_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [DATA_W-1:0] start_val;
    logic [DATA_W-1:0] scale_val;
    logic [DATA_W-1:0] count_q;
    logic              running;
    logic              go_cmd;
    logic              halt_cmd;
    logic              tick;
    logic              step_en;

    assign step_en = running && !go_cmd && !halt_cmd;

    timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .running(running),
        .count(count_q), .start_val(start_val), .scale_val(scale_val),
        .go_cmd(go_cmd), .halt_cmd(halt_cmd), .bus_rdata(bus_rdata)
    );

    timer_prescaler #(.W(DATA_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(go_cmd), .enable(step_en),
        .limit(scale_val), .tick(tick)
    );

    timer_core #(.W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .go(go_cmd), .halt(halt_cmd), .tick(tick),
        .start_val(start_val), .count(count_q), .running(running)
    );
endmodule

// File: rtl/prescale_timer_checker.sv
// Temporal properties of the prescaled timer, bound onto its top module.
module prescale_timer_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] start_val,
    input logic [DATA_W-1:0] scale_val,
    input logic              running,
    input logic              go_cmd,
    input logic              halt_cmd,
    input logic              tick
);
    AST_RUN_ABOVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> count_q > DATA_W'(1)); // R5
    AST_STOP_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !go_cmd && !halt_cmd && count_q == DATA_W'(2))
        |=> (!running && count_q == DATA_W'(1))); // R5
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !go_cmd && !halt_cmd) |=> count_q == $past(count_q) - DATA_W'(1)); // R4
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !go_cmd) |=> $stable(count_q)); // R6
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cmd |=> (!running && $stable(count_q))); // R7
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (running && bus_cs && bus_we) |=> ($stable(start_val) && $stable(scale_val))); // R8
    AST_GO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        go_cmd |=> count_q == $past(start_val)); // R3
endmodule

bind prescale_timer prescale_timer_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .count_q(count_q), .start_val(start_val), .scale_val(scale_val),
    .running(running), .go_cmd(go_cmd), .halt_cmd(halt_cmd), .tick(tick)
);

// File: tb/prescale_timer_bench.sv
module prescale_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model state
    longint m_count = 0, m_init = 0, m_scale = 0, m_phase = 0;
    bit m_run = 0;

    always #5 clk = ~clk;

    prescale_timer u_prescale_timer (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_read();
        if (!bus_cs || bus_we) return 0;
        case (bus_addr)
            4'd1: return longint'(m_run);
            4'd2: return m_init;
            4'd3: return m_scale;
            4'd4: return m_count;
            default: return 0;
        endcase
    endfunction

    // Model step at each edge, then compare read data shortly after.
    always @(posedge clk) begin
        bit was_run;
        was_run = m_run;
        if (!rst_n) begin
            m_count = 0; m_init = 0; m_scale = 0; m_phase = 0; m_run = 0;
        end else begin
            if (bus_cs && bus_we && bus_addr == 4'd0 && bus_wdata[0]) begin
                m_count = m_init; m_phase = 0; m_run = (m_init > 1);
            end else if (bus_cs && bus_we && bus_addr == 4'd0 && bus_wdata[1]) begin
                m_run = 0;
            end else if (was_run) begin
                if (m_phase == m_scale) begin
                    m_phase = 0;
                    m_count = m_count - 1;
                    if (m_count == 1) m_run = 0;
                end else m_phase = m_phase + 1;
            end
            if (bus_cs && bus_we && !was_run) begin
                if (bus_addr == 4'd2) m_init = bus_wdata;
                if (bus_addr == 4'd3) m_scale = bus_wdata;
            end
        end
        #2;
        if (rst_n && !done) chk(cur_req, bus_rdata, model_read());
    end

    task automatic wr(input int a, input longint d);
        @(negedge clk);
        bus_cs = 1; bus_we = 1; bus_addr = 4'(a); bus_wdata = 32'(d);
    endtask

    task automatic rd(input int a, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_cs = 1; bus_we = 0; bus_addr = 4'(a);
        end
    endtask

    // Read a register once and check it against an explicit expected value.
    task automatic peek(input string req, input int a, input longint exp);
        @(negedge clk);
        bus_cs = 1; bus_we = 0; bus_addr = 4'(a);
        #1 chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        peek("R1", 4, 0); peek("R1", 1, 0); peek("R1", 2, 0); peek("R1", 3, 0);
        cur_req = "R2";
        wr(2, 5); wr(3, 2);
        peek("R2", 2, 5); peek("R2", 3, 2);
        cur_req = "R3";
        wr(0, 1);
        peek("R3", 4, 5); peek("R3", 1, 1);
        cur_req = "R4";
        rd(4, 8);
        cur_req = "R5";
        rd(4, 8);
        peek("R5", 4, 1); peek("R5", 1, 0);
        cur_req = "R4";
        wr(2, 4); wr(3, 0); wr(0, 1); rd(4, 6);
        wr(2, 6); wr(3, 3); wr(0, 1); rd(4, 25);
        peek("R5", 4, 1);
        cur_req = "R6";
        wr(2, 1); wr(0, 1); rd(4, 4); peek("R6", 1, 0); peek("R6", 4, 1);
        wr(2, 0); wr(0, 1); rd(4, 4); peek("R6", 1, 0); peek("R6", 4, 0);
        cur_req = "R7";
        wr(2, 10); wr(3, 1); wr(0, 1); rd(4, 5);
        wr(0, 2); peek("R7", 1, 0); rd(4, 5); peek("R7", 4, 8);
        cur_req = "R8";
        wr(0, 1); wr(2, 99); wr(3, 7);
        peek("R8", 2, 10); peek("R8", 3, 1);
        cur_req = "R9";
        rd(4, 6); wr(0, 1); peek("R9", 4, 10); rd(4, 3);
        wr(0, 3); peek("R9", 1, 1); peek("R9", 4, 10);
        rd(4, 30);
        cur_req = "R10";
        peek("R10", 0, 0); peek("R10", 7, 0); peek("R10", 15, 0);
        @(negedge clk); bus_cs = 0; bus_addr = 4'd2;
        #1 chk("R10", bus_rdata, 0);
        @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = 4'd4;
        #1 chk("R10", bus_rdata, 0);
        @(negedge clk); bus_cs = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule